// File: doc/BRIEF.md
# Cache Request QoS Arbiter with Display Service Window

This block sits in front of a shared last-level cache and picks one request per cycle from a set of sources. Each source presents a valid bit, a 3-bit service class and a target bank number. The numerically smallest class present wins. Among sources of the same class, the block rotates fairly by source index. The grant is a registered one-hot vector. A source whose grant is showing in a cycle is treated as accepted in that cycle, so it cannot win again in that same cycle.

With each grant the block also produces the set of ways the request may allocate into. This set is the programmable way-allocation mask of the winning class, combined with the way-enable mask of the target bank, so that partitioning by class and power-down of ways both apply. If the combined set is empty, the request is still granted but is marked as no-allocate. A programmable service window tracks how long the display class (class 0) has gone without a grant. A class-0 grant made after that window has run out is flagged with a one-cycle hold pulse. A level output shows that at least one way in at least one bank is switched off.

Top module: `llc_qos_arbiter`

## Requirements
- R1: While `rstN` is low, and on the first cycle after reset, `grant`, `allowWays`, `noAlloc` and `holdPulse` are all zero. The internal rotation pointer and the window counter start at zero.
- R2: The grant is one-hot and appears one clock after the request is sampled. A source whose grant bit is high in a cycle is not eligible in that cycle, so the same source is never granted on two consecutive cycles.
- R3: Source i takes its class from `reqClass[3i+2:3i]` (0..7). Among eligible sources, the one with the lowest class value is granted. `grantClass` and `grantBank` carry the class and bank of the winner.
- R4: Among eligible sources of the same lowest class, the search starts at the rotation pointer and moves up by index, wrapping around. After each grant the pointer becomes the winner's index plus one, modulo NUM_SRC.
- R5: `allowWays` equals `wayAllocMask[NUM_WAYS*c +: NUM_WAYS]` AND `wayEnableMask[NUM_WAYS*b +: NUM_WAYS]`, where c is the winner's class and b is its bank (`reqBank[BANK_W*i +: BANK_W]`).
- R6: When a grant's `allowWays` is all zero, `noAlloc` is 1 in the same cycle as the grant and the grant is still issued. In all other cycles `noAlloc` is 0.
- R7: A window counter clears on every class-0 grant. Otherwise it counts up each cycle and stops at `winCycles`. A class-0 grant decided while `winCycles` is nonzero and the counter is at or above `winCycles` raises `holdPulse` for exactly the cycle in which that grant shows.
- R8: With `winCycles` equal to zero, `holdPulse` never rises.
- R9: `shutoffActive` is 1 one clock after any bit of `wayEnableMask` is 0, and is 0 one clock after all bits are 1.
- R10: In a cycle with no eligible request, no grant is issued and `allowWays`, `noAlloc` and `holdPulse` are 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_SRC | Request valid per source |
| reqClass | input | 3*NUM_SRC | Service class per source, 3 bits each |
| reqBank | input | BANK_W*NUM_SRC | Target bank per source |
| winCycles | input | WIN_W | Display service window length, 0 disables the hold pulse |
| wayAllocMask | input | 8*NUM_WAYS | Allowed ways per class, class c at bits NUM_WAYS*c |
| wayEnableMask | input | NUM_BANKS*NUM_WAYS | Powered-on ways per bank |
| grant | output | NUM_SRC | Registered one-hot grant |
| grantClass | output | 3 | Class of the granted request |
| grantBank | output | BANK_W | Bank of the granted request |
| allowWays | output | NUM_WAYS | Ways the granted request may allocate into |
| noAlloc | output | 1 | Granted request has no allowed way |
| holdPulse | output | 1 | Class-0 grant after the window ran out |
| shutoffActive | output | 1 | Some way in some bank is disabled |

## Verification
The case that is hardest to reach from the ports is the expired-window hold. Strict priority serves class 0 as soon as it appears, so the counter only reaches its limit if class 0 stays absent for a full window while other traffic keeps the arbiter busy. The stimulus therefore runs several cycles of class-3 traffic with a short window. It then brings in a class-0 request and checks the pulse, then a second class-0 request right after it to check that no pulse follows. A long pseudo-random phase is compared cycle by cycle against an arithmetic model of priority, rotation, masking, the counter and the masks. This phase also catches windows that run out by chance.

// File: rtl/llc_qos_pkg.sv
package llc_qos_pkg;
  localparam int CLASS_W   = 3;
  localparam int NUM_CLASS = 1 << CLASS_W;
  localparam int IDX_W     = 8;

  // Strobes handed from the control module to the datapath each cycle
  typedef struct packed {
    logic             grantEn;
    logic [IDX_W-1:0] winIdx;
    logic             hold;
  } arbStrobe_t;
endpackage

// File: rtl/llc_qos_ctrl.sv
module llc_qos_ctrl
  import llc_qos_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int WIN_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         reqValid,
  input  logic [NUM_SRC*CLASS_W-1:0] reqClass,
  input  logic [NUM_SRC-1:0]         grantQ,
  input  logic [WIN_W-1:0]           winCycles,
  output arbStrobe_t                 strobe
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [CLASS_W-1:0] clsArr [NUM_SRC];
  logic [NUM_SRC-1:0] eligible;
  logic [CLASS_W-1:0] minCls;
  logic               found;
  logic [SRC_W-1:0]   winIdx;
  logic [SRC_W-1:0]   rrPtr;
  logic [SRC_W-1:0]   nextPtr;
  logic [WIN_W-1:0]   cnt;
  logic               expired;
  logic               cls0Grant;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_unpack
    assign clsArr[i] = reqClass[i*CLASS_W +: CLASS_W];
  end

  // The source shown as granted this cycle is being accepted now
  assign eligible = reqValid & ~grantQ;

  always_comb begin
    minCls = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (clsArr[i] < minCls)) minCls = clsArr[i];
    end
    found  = 1'b0;
    winIdx = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      int idx;
      idx = int'(rrPtr) + k;
      if (idx >= NUM_SRC) idx = idx - NUM_SRC;
      if (!found && eligible[idx] && (clsArr[idx] == minCls)) begin
        found  = 1'b1;
        winIdx = SRC_W'(idx);
      end
    end
  end

  assign nextPtr   = (winIdx == SRC_W'(NUM_SRC - 1)) ? '0 : winIdx + 1'b1;
  assign expired   = (winCycles != '0) && (cnt >= winCycles);
  assign cls0Grant = found && (minCls == '0);

  assign strobe.grantEn = found;
  assign strobe.winIdx  = IDX_W'(winIdx);
  assign strobe.hold    = cls0Grant && expired;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
      cnt   <= '0;
    end else begin
      if (found) rrPtr <= nextPtr;
      if (cls0Grant)            cnt <= '0;
      else if (cnt < winCycles) cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    cls0Grant |=> (cnt == '0)); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1))); // R7

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(rrPtr) < NUM_SRC); // R4
endmodule

// File: rtl/llc_qos_dpath.sv
module llc_qos_dpath
  import llc_qos_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int NUM_WAYS  = 4,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  arbStrobe_t                      strobe,
  input  logic [NUM_SRC*CLASS_W-1:0]      reqClass,
  input  logic [NUM_SRC*BANK_W-1:0]       reqBank,
  input  logic [NUM_CLASS*NUM_WAYS-1:0]   wayAllocMask,
  input  logic [NUM_BANKS*NUM_WAYS-1:0]   wayEnableMask,
  output logic [NUM_SRC-1:0]              grantQ,
  output logic [CLASS_W-1:0]              grantClass,
  output logic [BANK_W-1:0]               grantBank,
  output logic [NUM_WAYS-1:0]             allowWays,
  output logic                            noAlloc,
  output logic                            holdPulse,
  output logic                            shutoffActive
);
  logic [CLASS_W-1:0]  selCls;
  logic [BANK_W-1:0]   selBank;
  logic [NUM_WAYS-1:0] allocSel;
  logic [NUM_WAYS-1:0] enableSel;
  logic [NUM_WAYS-1:0] waysNext;
  logic [NUM_BANKS-1:0] bankOff;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankOff[b] = ~&wayEnableMask[b*NUM_WAYS +: NUM_WAYS];
  end

  always_comb begin
    selCls   = reqClass[int'(strobe.winIdx)*CLASS_W +: CLASS_W];
    selBank  = reqBank[int'(strobe.winIdx)*BANK_W +: BANK_W];
    allocSel = wayAllocMask[int'(selCls)*NUM_WAYS +: NUM_WAYS];
    if (int'(selBank) < NUM_BANKS) enableSel = wayEnableMask[int'(selBank)*NUM_WAYS +: NUM_WAYS];
    else                           enableSel = '0;
    waysNext = allocSel & enableSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ        <= '0;
      grantClass    <= '0;
      grantBank     <= '0;
      allowWays     <= '0;
      noAlloc       <= 1'b0;
      holdPulse     <= 1'b0;
      shutoffActive <= 1'b0;
    end else begin
      shutoffActive <= |bankOff;
      if (strobe.grantEn) begin
        grantQ     <= NUM_SRC'(1) << strobe.winIdx;
        grantClass <= selCls;
        grantBank  <= selBank;
        allowWays  <= waysNext;
        noAlloc    <= (waysNext == '0);
        holdPulse  <= strobe.hold;
      end else begin
        grantQ     <= '0;
        grantClass <= '0;
        grantBank  <= '0;
        allowWays  <= '0;
        noAlloc    <= 1'b0;
        holdPulse  <= 1'b0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ == '0) |-> ((allowWays == '0) && !noAlloc && !holdPulse)); // R10

  AST_HOLD_CLASS0: assert property (@(posedge clk) disable iff (!rstN)
    holdPulse |-> (grantClass == '0)); // R7

  AST_NOALLOC_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    noAlloc |-> (grantQ != '0)); // R6

  AST_WAYS_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ != '0) |-> ((allowWays & ~$past(enableSel)) == '0)); // R5
endmodule

// File: rtl/llc_qos_arbiter.sv
module llc_qos_arbiter
  import llc_qos_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int NUM_WAYS  = 4,
  parameter int NUM_BANKS = 2,
  parameter int WIN_W     = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_SRC-1:0]                  reqValid,
  input  logic [NUM_SRC*3-1:0]                reqClass,
  input  logic [NUM_SRC*BANK_W-1:0]           reqBank,
  input  logic [WIN_W-1:0]                    winCycles,
  input  logic [8*NUM_WAYS-1:0]               wayAllocMask,
  input  logic [NUM_BANKS*NUM_WAYS-1:0]       wayEnableMask,
  output logic [NUM_SRC-1:0]                  grant,
  output logic [2:0]                          grantClass,
  output logic [BANK_W-1:0]                   grantBank,
  output logic [NUM_WAYS-1:0]                 allowWays,
  output logic                                noAlloc,
  output logic                                holdPulse,
  output logic                                shutoffActive
);
  arbStrobe_t strobe;

  llc_qos_ctrl #(.NUM_SRC(NUM_SRC), .WIN_W(WIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqClass(reqClass),
    .grantQ(grant), .winCycles(winCycles), .strobe(strobe)
  );

  llc_qos_dpath #(.NUM_SRC(NUM_SRC), .NUM_WAYS(NUM_WAYS), .NUM_BANKS(NUM_BANKS),
                  .BANK_W(BANK_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqClass(reqClass), .reqBank(reqBank),
    .wayAllocMask(wayAllocMask), .wayEnableMask(wayEnableMask),
    .grantQ(grant), .grantClass(grantClass), .grantBank(grantBank),
    .allowWays(allowWays), .noAlloc(noAlloc), .holdPulse(holdPulse),
    .shutoffActive(shutoffActive)
  );

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R2

  AST_GRANT_HAD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~$past(reqValid)) == '0); // R2

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    (grant & $past(grant)) == '0); // R2
endmodule

// File: tb/tb_llc_qos_arbiter.sv
module tb_llc_qos_arbiter;
  localparam int N = 4;
  localparam int W = 4;
  localparam int B = 2;
  localparam int WW = 4;

  logic clk = 1'b0;
  logic rstN;
  logic [N-1:0]   reqValid;
  logic [N*3-1:0] reqClass;
  logic [N-1:0]   reqBank;
  logic [WW-1:0]  winCycles;
  logic [8*W-1:0] wayAllocMask;
  logic [B*W-1:0] wayEnableMask;
  logic [N-1:0]   grant;
  logic [2:0]     grantClass;
  logic [0:0]     grantBank;
  logic [W-1:0]   allowWays;
  logic           noAlloc, holdPulse, shutoffActive;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int mRr, mCnt, mPrev;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  llc_qos_arbiter #(.NUM_SRC(N), .NUM_WAYS(W), .NUM_BANKS(B), .WIN_W(WW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqClass(reqClass), .reqBank(reqBank),
    .winCycles(winCycles), .wayAllocMask(wayAllocMask), .wayEnableMask(wayEnableMask),
    .grant(grant), .grantClass(grantClass), .grantBank(grantBank), .allowWays(allowWays),
    .noAlloc(noAlloc), .holdPulse(holdPulse), .shutoffActive(shutoffActive)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // One clock: model computes expectations from the current inputs, then compares
  task automatic step();
    int minC, win, c, b;
    bit found, expHold;
    logic [W-1:0] expWays;
    minC = 7; found = 0; win = 0;
    for (int i = 0; i < N; i++)
      if (reqValid[i] && i != mPrev && int'(reqClass[i*3 +: 3]) < minC) minC = int'(reqClass[i*3 +: 3]);
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (mRr + k) % N;
      if (!found && reqValid[idx] && idx != mPrev && int'(reqClass[idx*3 +: 3]) == minC) begin
        found = 1; win = idx;
      end
    end
    c = found ? int'(reqClass[win*3 +: 3]) : 0;
    b = found ? int'(reqBank[win]) : 0;
    expWays = found ? (wayAllocMask[c*W +: W] & wayEnableMask[b*W +: W]) : '0;
    expHold = found && (minC == 0) && (winCycles != 0) && (mCnt >= int'(winCycles));
    // model state update
    mPrev = found ? win : -1;
    if (found) mRr = (win + 1) % N;
    if (found && minC == 0) mCnt = 0;
    else if (mCnt < int'(winCycles)) mCnt++;
    @(posedge clk); #1;
    check(grant == (found ? N'(1 << win) : N'(0)), "R3 R4 grant", int'(grant), found ? (1 << win) : 0);
    if (found) check(grantClass == 3'(c) && grantBank == 1'(b), "R3 class/bank", {grantClass, grantBank}, (c << 1) | b);
    check(allowWays == expWays, "R5 allowWays", int'(allowWays), int'(expWays));
    check(noAlloc == (found && expWays == 0), "R6 noAlloc", int'(noAlloc), int'(found && expWays == 0));
    check(holdPulse == expHold, "R7 holdPulse", int'(holdPulse), int'(expHold));
    check(shutoffActive == ~&wayEnableMask, "R9 shutoff", int'(shutoffActive), int'(~&wayEnableMask));
  endtask

  task automatic setOne(input int src, input int cls, input int bank);
    reqValid = '0;
    reqValid[src] = 1'b1;
    reqClass[src*3 +: 3] = 3'(cls);
    reqBank[src] = 1'(bank);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = '1; reqClass = '0; reqBank = '0; winCycles = 4'd5;
    wayAllocMask = '1; wayEnableMask = '1;
    mRr = 0; mCnt = 0; mPrev = -1;
    repeat (3) @(posedge clk); #1;
    // R1: reset state
    check(grant == 0 && allowWays == 0 && !noAlloc && !holdPulse, "R1 reset", int'(grant), 0);
    reqValid = '0;
    rstN = 1'b1;
    @(posedge clk); #1;
    check(grant == 0 && allowWays == 0 && !noAlloc && !holdPulse, "R1 first cycle", int'(grant), 0);
    mCnt = 1;
    // R10: idle
    step(); step();
    check(grant == 0, "R10 idle", int'(grant), 0);

    // R2: one source held valid alternates grant / no grant
    setOne(1, 5, 0);
    step(); check(grant == 4'b0010, "R2 first grant", int'(grant), 2);
    step(); check(grant == 4'b0000, "R2 masked repeat", int'(grant), 0);
    step(); check(grant == 4'b0010, "R2 regrant", int'(grant), 2);
    reqValid = '0; step();

    // R3: lowest class wins
    reqValid = 4'b1111;
    reqClass = {3'd6, 3'd2, 3'd4, 3'd7};
    step(); check(grant == 4'b0100, "R3 lowest class", int'(grant), 4);
    reqValid = '0; step();

    // R4: equal classes rotate
    reqClass = '0; winCycles = 4'd0;
    reqValid = 4'b1011;
    for (int r = 0; r < 6; r++) step();
    reqValid = '0; step();

    // R5/R6: sweep every class against every bank
    winCycles = 4'd5;
    for (int c = 0; c < 8; c++) wayAllocMask[c*W +: W] = 4'((c * 5 + 3) % 16);
    for (int e = 0; e < 3; e++) begin
      wayEnableMask = (e == 0) ? 8'hFF : (e == 1) ? 8'h5B : 8'h0D;
      for (int c = 0; c < 8; c++)
        for (int b = 0; b < B; b++) begin
          setOne(2, c, b);
          step();
          check(allowWays == (4'((c * 5 + 3) % 16) & wayEnableMask[b*W +: W]), "R5 sweep",
                int'(allowWays), int'(4'((c * 5 + 3) % 16) & wayEnableMask[b*W +: W]));
          reqValid = '0; step();
        end
    end
    // R6: empty mask still grants
    wayAllocMask[3*W +: W] = 4'b0000;
    setOne(0, 3, 1); step();
    check(noAlloc && grant == 4'b0001, "R6 no-allocate grant", int'(noAlloc), 1);
    reqValid = '0; step();

    // R7: window expiry with class-0 absent
    wayAllocMask = '1; wayEnableMask = '1; winCycles = 4'd3;
    setOne(2, 0, 0); step(); reqValid = '0; step();
    setOne(1, 3, 0); reqValid[3] = 1'b1; reqClass[3*3 +: 3] = 3'd3;
    for (int r = 0; r < 6; r++) step();
    setOne(0, 0, 0); step();
    check(holdPulse == 1'b1, "R7 hold after expiry", int'(holdPulse), 1);
    setOne(3, 0, 1); step();
    check(holdPulse == 1'b0, "R7 no hold right after", int'(holdPulse), 0);
    reqValid = '0; step();

    // R8: window disabled
    winCycles = 4'd0;
    setOne(1, 3, 0);
    for (int r = 0; r < 8; r++) step();
    setOne(0, 0, 0); step();
    check(holdPulse == 1'b0, "R8 disabled window", int'(holdPulse), 0);
    reqValid = '0; step();

    // R9: shutoff level follows enable mask
    wayEnableMask = 8'hF7; step();
    check(shutoffActive == 1'b1, "R9 shutoff on", int'(shutoffActive), 1);
    wayEnableMask = 8'hFF; step();
    check(shutoffActive == 1'b0, "R9 shutoff off", int'(shutoffActive), 0);

    // Pseudo-random traffic against the model (R2..R7, R9, R10)
    winCycles = 4'd4;
    for (int r = 0; r < 3000; r++) begin
      logic [31:0] x, y;
      x = nextRand(); y = nextRand();
      reqValid = 4'(x[7:4] & x[11:8] | x[15:12]);
      reqClass = 12'(y[27:16] | {4{x[3], 2'b00}});
      reqBank  = 4'(y[31:28]);
      if (r % 97 == 0) begin
        wayEnableMask = 8'(nextRand() >> 8);
        wayAllocMask  = 32'(nextRand());
        winCycles     = 4'(r % 7);
      end
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule